// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind the bit-level receiver of an I2C slave and judges each byte that arrives after a START or repeated START. It decides whether the byte addresses this device and, for every received byte, reports whether the acknowledge slot should carry ACK or NACK. It recognizes three kinds of address: a 7-bit own address, a 10-bit own address and the general call address. Each kind has its own acknowledge enable.

The receiver supplies a byte strobe, the byte, and a flag that marks the first byte after a START. The recognizer sends back a registered ACK decision one cycle after the strobe. It also reports an addressed-as-slave flag, a general-call flag and the transfer direction. When addressing completes, it pulses an address-phase-complete signal together with that decision. For a 10-bit address this pulse comes after the second byte; for a 7-bit address or a general call it comes after the first byte. If no address matches, the block returns NACK and stays silent until the next START or STOP.

Top module: `i2c_addr_recog`

## Requirements
- R1: After reset, and for any byte received before the first START, `ack_vld_o` pulses with `ack_o`=0. `addressed_o`, `gen_call_o` and `addr_done_o` stay 0.
- R2: A first byte whose bits 7:1 equal `own_addr7_i` is answered with ACK when `en7_i`=1. It then sets `addressed_o`, sets `rw_o` to bit 0 of the byte, and pulses `addr_done_o`. With `en7_i`=0 the same byte gets NACK and nothing is set.
- R3: A first byte of 0x00 is the general call. It gets ACK, sets `gen_call_o` and `addressed_o` with `rw_o`=0, and pulses `addr_done_o`, but only if `gc_en_i`=1. Otherwise it gets NACK.
- R4: A first byte of the form 11110, A9, A8, 0 (bits 7:3, 2:1, 0), where A9:A8 equal `own_addr10_i[9:8]` and `en10_i`=1, gets ACK. This byte leaves `addressed_o` low and gives no `addr_done_o`. If the next byte equals `own_addr10_i[7:0]`, it gets ACK, sets `addressed_o` with `rw_o`=0, and pulses `addr_done_o`; any other value gets NACK.
- R5: With `en10_i`=0, a 10-bit first byte gets NACK.
- R6: After a completed 10-bit write addressing, a repeated START followed by the matching first byte with bit 0 = 1 gets ACK. It sets `addressed_o` with `rw_o`=1 and pulses `addr_done_o` with no second byte.
- R7: A matching 10-bit first byte with bit 0 = 1 gets NACK unless a 10-bit write addressing completed earlier, after the last STOP and with no other first byte since.
- R8: `data_ack_en_i` has no effect on the decision for address bytes. For data bytes while addressed, `ack_o` equals `data_ack_en_i`.
- R9: A non-matching first byte gets NACK, and every later byte also gets NACK until a START or STOP.
- R10: STOP clears `addressed_o` and `gen_call_o` and forgets a 10-bit write addressing. START clears `addressed_o` and `gen_call_o` and waits for a first byte.
- R11: `ack_vld_o` is a one-cycle pulse in the cycle after `byte_vld_i`, with `ack_o` valid in that cycle. `addr_done_o` pulses only in that same cycle.
- R12: When one first byte matches more than one kind of address, the general call takes precedence over the 10-bit address, and the 10-bit address takes precedence over the 7-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START detected (one cycle) |
| stop_i | input | 1 | STOP detected (one cycle) |
| byte_vld_i | input | 1 | Received byte strobe |
| first_byte_i | input | 1 | Strobed byte is the first after START |
| byte_i | input | 8 | Received byte |
| own_addr7_i | input | 7 | 7-bit own address |
| own_addr10_i | input | 10 | 10-bit own address |
| en7_i | input | 1 | Acknowledge enable for the 7-bit address |
| en10_i | input | 1 | Acknowledge enable for the 10-bit address |
| gc_en_i | input | 1 | Acknowledge enable for the general call |
| data_ack_en_i | input | 1 | Acknowledge enable for data bytes |
| ack_vld_o | output | 1 | ACK decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| addressed_o | output | 1 | Device is addressed as slave |
| gen_call_o | output | 1 | Addressed through the general call |
| rw_o | output | 1 | Direction of the addressed transfer, 1 = read |
| addr_done_o | output | 1 | Address phase complete (one cycle) |

## Verification
The address matcher is driven with each kind of address under each enable setting:

- 7-bit writes and reads with the enable on and off.
- The general call with its enable on and off.
- 10-bit write addressing with a correct and a wrong second byte, and with the 10-bit enable off.
- The repeated-START read shortcut, both after a 10-bit write and without one.

Each pattern separates a real match from a prefix-only match or a match on a disabled address.

Non-matching bytes followed by data bytes show that the block ignores the bus until START or STOP. Address bytes are sent with the data acknowledge enable cleared, and data bytes are sent with it toggled, to show that the enable only affects data bytes. A 7-bit own address that also has the 10-bit prefix form shows the precedence order.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_DATA   = 2'd3
  } ar_state_e;

  typedef struct packed {
    logic gc;     // general call byte
    logic pfx10;  // 10-bit prefix with own A9:A8
    logic hit7;   // 7-bit own address
    logic lo10;   // byte equals own A7:A0
    logic rw;     // direction bit of the byte
  } ar_match_t;
endpackage

// File: rtl/ar_addr_match.sv
module ar_addr_match
  import i2c_ar_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int A7_W   = 7,
  parameter int A10_W  = 10
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [A7_W-1:0]   own_addr7_i,
  input  logic [A10_W-1:0]  own_addr10_i,
  output ar_match_t         match_o
);
  localparam int HI_W  = A10_W - BYTE_W;
  localparam int TAG_W = BYTE_W - 1 - HI_W;
  localparam logic [TAG_W-1:0] TAG10 = {{(TAG_W-1){1'b1}}, 1'b0};

  logic [BYTE_W-1:0] lo_eq;

  // per-bit equality against the low part of the 10-bit address
  for (genvar i = 0; i < BYTE_W; i++) begin : g_lo
    assign lo_eq[i] = byte_i[i] ~^ own_addr10_i[i];
  end

  always_comb begin
    match_o.gc    = (byte_i == '0);
    match_o.pfx10 = (byte_i[BYTE_W-1 -: TAG_W] == TAG10) &&
                    (byte_i[HI_W:1] == own_addr10_i[A10_W-1 -: HI_W]);
    match_o.hit7  = (byte_i[BYTE_W-1:1] == own_addr7_i);
    match_o.lo10  = &lo_eq;
    match_o.rw    = byte_i[0];
  end
endmodule

// File: rtl/ar_fsm.sv
module ar_fsm
  import i2c_ar_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      byte_vld_i,
  input  logic      first_byte_i,
  input  ar_match_t match_i,
  input  logic      en7_i,
  input  logic      en10_i,
  input  logic      gc_en_i,
  input  logic      data_ack_en_i,
  output logic      ack_vld_o,
  output logic      ack_o,
  output logic      addressed_o,
  output logic      gen_call_o,
  output logic      rw_o,
  output logic      addr_done_o
);
  ar_state_e st_q, st_d;
  logic armed_q, armed_d;
  logic addr_q, addr_d, gc_q, gc_d, rw_q, rw_d;
  logic ackv_q, ackv_d, ack_q, ack_d, done_q, done_d;

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    addr_d  = addr_q;
    gc_d    = gc_q;
    rw_d    = rw_q;
    ack_d   = ack_q;
    ackv_d  = 1'b0;
    done_d  = 1'b0;
    if (stop_i) begin
      st_d    = ST_IDLE;
      armed_d = 1'b0;
      addr_d  = 1'b0;
      gc_d    = 1'b0;
    end else if (start_i) begin
      st_d   = ST_FIRST;
      addr_d = 1'b0;
      gc_d   = 1'b0;
    end else if (byte_vld_i) begin
      ackv_d = 1'b1;
      ack_d  = 1'b0;
      unique case (st_q)
        ST_FIRST: begin
          st_d    = ST_IDLE;
          armed_d = 1'b0;
          if (first_byte_i) begin
            if (match_i.gc) begin
              if (gc_en_i) begin
                ack_d  = 1'b1;
                addr_d = 1'b1;
                gc_d   = 1'b1;
                rw_d   = 1'b0;
                done_d = 1'b1;
                st_d   = ST_DATA;
              end
            end else if (match_i.pfx10 && en10_i) begin
              if (!match_i.rw) begin
                ack_d = 1'b1;
                st_d  = ST_SECOND;
              end else if (armed_q) begin
                // repeated START read after 10-bit write addressing
                ack_d   = 1'b1;
                addr_d  = 1'b1;
                rw_d    = 1'b1;
                done_d  = 1'b1;
                armed_d = 1'b1;
                st_d    = ST_DATA;
              end
            end else if (match_i.hit7 && en7_i) begin
              ack_d  = 1'b1;
              addr_d = 1'b1;
              rw_d   = match_i.rw;
              done_d = 1'b1;
              st_d   = ST_DATA;
            end
          end
        end
        ST_SECOND: begin
          st_d = ST_IDLE;
          if (!first_byte_i && match_i.lo10) begin
            ack_d   = 1'b1;
            addr_d  = 1'b1;
            rw_d    = 1'b0;
            done_d  = 1'b1;
            armed_d = 1'b1;
            st_d    = ST_DATA;
          end
        end
        ST_DATA: ack_d = data_ack_en_i;
        default: ack_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      armed_q <= 1'b0;
      addr_q  <= 1'b0;
      gc_q    <= 1'b0;
      rw_q    <= 1'b0;
      ackv_q  <= 1'b0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
      addr_q  <= addr_d;
      gc_q    <= gc_d;
      rw_q    <= rw_d;
      ackv_q  <= ackv_d;
      ack_q   <= ack_d;
      done_q  <= done_d;
    end
  end

  assign ack_vld_o   = ackv_q;
  assign ack_o       = ack_q;
  assign addressed_o = addr_q;
  assign gen_call_o  = gc_q;
  assign rw_o        = rw_q;
  assign addr_done_o = done_q;

  p_vld_next_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !start_i && !stop_i) |=> ack_vld_o);
  p_done_with_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_done_o |-> (ack_vld_o && ack_o && addressed_o));
  p_gc_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gen_call_o) |-> $past(gc_en_i));
  p_stop_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!addressed_o && !gen_call_o));
  p_ignore_nack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && byte_vld_i && !start_i && !stop_i) |=> !ack_o);
  p_prefix_no_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIRST && byte_vld_i && first_byte_i && !start_i && !stop_i &&
     !match_i.gc && match_i.pfx10 && !match_i.rw && en10_i) |=> (!addressed_o && ack_o));
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
  import i2c_ar_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int A7_W   = BYTE_W - 1,
  parameter int A10_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic              first_byte_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [A7_W-1:0]   own_addr7_i,
  input  logic [A10_W-1:0]  own_addr10_i,
  input  logic              en7_i,
  input  logic              en10_i,
  input  logic              gc_en_i,
  input  logic              data_ack_en_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic              addressed_o,
  output logic              gen_call_o,
  output logic              rw_o,
  output logic              addr_done_o
);
  ar_match_t match;

  ar_addr_match #(.BYTE_W(BYTE_W), .A7_W(A7_W), .A10_W(A10_W)) u_match (
    .byte_i      (byte_i),
    .own_addr7_i (own_addr7_i),
    .own_addr10_i(own_addr10_i),
    .match_o     (match)
  );

  ar_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_vld_i   (byte_vld_i),
    .first_byte_i (first_byte_i),
    .match_i      (match),
    .en7_i        (en7_i),
    .en10_i       (en10_i),
    .gc_en_i      (gc_en_i),
    .data_ack_en_i(data_ack_en_i),
    .ack_vld_o    (ack_vld_o),
    .ack_o        (ack_o),
    .addressed_o  (addressed_o),
    .gen_call_o   (gen_call_o),
    .rw_o         (rw_o),
    .addr_done_o  (addr_done_o)
  );

  p_gc_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_call_o |-> (addressed_o && !rw_o));
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_done_o |=> !addr_done_o);
endmodule

// File: tb/i2c_addr_recog_test.sv
module i2c_addr_recog_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, stop = 0, bvld = 0, first = 0;
  logic [7:0] bdat = '0;
  logic [6:0] own7 = 7'h3A;
  logic [9:0] own10 = 10'h2C5;
  logic en7 = 1, en10 = 1, gcen = 0, daen = 1;
  logic ack_vld, ack, addressed, gen_call, rw, done;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_addr_recog uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_vld_i(bvld), .first_byte_i(first), .byte_i(bdat),
    .own_addr7_i(own7), .own_addr10_i(own10), .en7_i(en7), .en10_i(en10),
    .gc_en_i(gcen), .data_ack_en_i(daen), .ack_vld_o(ack_vld), .ack_o(ack),
    .addressed_o(addressed), .gen_call_o(gen_call), .rw_o(rw), .addr_done_o(done)
  );

  // behavioural reference: 0 ignore, 1 expect first, 2 expect low byte, 3 data
  int mode;
  bit m_mem10, m_addr, m_gc, m_rw, m_ackv, m_ack, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; m_mem10 = 0; m_addr = 0; m_gc = 0; m_rw = 0;
      m_ackv = 0; m_ack = 0; m_done = 0;
    end else begin
      m_ackv = 0; m_done = 0;
      if (stop) begin
        mode = 0; m_mem10 = 0; m_addr = 0; m_gc = 0;
      end else if (start) begin
        mode = 1; m_addr = 0; m_gc = 0;
      end else if (bvld) begin
        m_ackv = 1; m_ack = 0;
        if (mode == 3) m_ack = daen;
        else if (mode == 2) begin
          mode = 0;
          if (!first && bdat == own10[7:0]) begin
            m_ack = 1; m_addr = 1; m_rw = 0; m_done = 1; m_mem10 = 1; mode = 3;
          end
        end else if (mode == 1) begin
          bit was10;
          was10 = m_mem10;
          m_mem10 = 0; mode = 0;
          if (first) begin
            if (bdat == 8'h00) begin
              if (gcen) begin m_ack = 1; m_addr = 1; m_gc = 1; m_rw = 0; m_done = 1; mode = 3; end
            end else if (en10 && bdat[7:3] == 5'b11110 && bdat[2:1] == own10[9:8]) begin
              if (bdat[0] == 0) begin m_ack = 1; mode = 2; end
              else if (was10) begin
                m_ack = 1; m_addr = 1; m_rw = 1; m_done = 1; m_mem10 = 1; mode = 3;
              end
            end else if (en7 && bdat[7:1] == own7) begin
              m_ack = 1; m_addr = 1; m_rw = bdat[0]; m_done = 1; mode = 3;
            end
          end
        end
      end
    end
  end

  task automatic cmp(input logic act, input bit exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp(ack_vld, m_ackv, "ack_vld");
      if (m_ackv) cmp(ack, m_ack, "ack");
      cmp(addressed, m_addr, "addressed");
      cmp(gen_call, m_gc, "gen_call");
      cmp(done, m_done, "addr_done");
      if (m_addr) cmp(rw, m_rw, "rw");
    end
  end

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask
  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask
  // after return the outputs show the decision for this byte
  task automatic send(input logic [7:0] b, input logic f);
    @(negedge clk); bvld = 1; bdat = b; first = f;
    @(negedge clk); bvld = 0; first = 0;
  endtask
  task automatic expect_dec(input bit e_ack, input bit e_addr, input bit e_done, input string req);
    cur_req = req;
    cmp(ack_vld, 1'b1, "direct ack_vld");
    cmp(ack, e_ack, "direct ack");
    cmp(addressed, e_addr, "direct addressed");
    cmp(done, e_done, "direct addr_done");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    cmp(addressed, 1'b0, "reset addressed");
    cmp(ack_vld, 1'b0, "reset ack_vld");
    cmp(gen_call, 1'b0, "reset gen_call");
    cmp(done, 1'b0, "reset addr_done");
    rst_n = 1;
    send(8'h74, 1); expect_dec(0, 0, 0, "R1");

    // R2: 7-bit write, data bytes under R8
    do_start(); send(8'h74, 1); expect_dec(1, 1, 1, "R2");
    cmp(rw, 1'b0, "R2 rw write");
    cur_req = "R8"; daen = 1; send(8'h55, 0); expect_dec(1, 1, 0, "R8");
    daen = 0; send(8'hAA, 0); expect_dec(0, 1, 0, "R8");
    cur_req = "R11"; @(negedge clk); cmp(ack_vld, 1'b0, "R11 single pulse");
    do_stop(); cur_req = "R10"; cmp(addressed, 1'b0, "R10 stop clears");
    // R8: address ACK independent of data enable (still 0)
    do_start(); send(8'h75, 1); expect_dec(1, 1, 1, "R8");
    cmp(rw, 1'b1, "R2 rw read");
    do_stop(); daen = 1;

    // R2 disabled, R9 ignoring
    en7 = 0; do_start(); send(8'h74, 1); expect_dec(0, 0, 0, "R2");
    send(8'h74, 0); expect_dec(0, 0, 0, "R9");
    send(8'h12, 0); expect_dec(0, 0, 0, "R9");
    en7 = 1;
    do_start(); send(8'h20, 1); expect_dec(0, 0, 0, "R9");
    send(8'h33, 0); expect_dec(0, 0, 0, "R9");
    do_start(); send(8'h74, 1); expect_dec(1, 1, 1, "R9");
    do_start(); cur_req = "R10"; cmp(addressed, 1'b0, "R10 start clears");
    do_stop();

    // R3 general call
    gcen = 0; do_start(); send(8'h00, 1); expect_dec(0, 0, 0, "R3");
    gcen = 1; do_start(); send(8'h00, 1); expect_dec(1, 1, 1, "R3");
    cmp(gen_call, 1'b1, "R3 gen_call");
    send(8'h9C, 0); expect_dec(1, 1, 0, "R3");
    do_start(); cmp(gen_call, 1'b0, "R10 start clears gc");
    send(8'h01, 1); expect_dec(0, 0, 0, "R3");
    do_stop();

    // R4 10-bit
    do_start(); send(8'hF4, 1); expect_dec(1, 0, 0, "R4");
    send(8'hC5, 0); expect_dec(1, 1, 1, "R4");
    send(8'h11, 0); expect_dec(1, 1, 0, "R4");
    // R6 repeated start read
    do_start(); send(8'hF5, 1); expect_dec(1, 1, 1, "R6");
    cmp(rw, 1'b1, "R6 rw read");
    do_start(); send(8'hF5, 1); expect_dec(1, 1, 1, "R6");
    do_stop();
    // R7 read without prior write addressing
    do_start(); send(8'hF5, 1); expect_dec(0, 0, 0, "R7");
    do_start(); send(8'hF4, 1); expect_dec(1, 0, 0, "R4");
    send(8'hC4, 0); expect_dec(0, 0, 0, "R4");
    send(8'hC5, 0); expect_dec(0, 0, 0, "R9");
    do_start(); send(8'hF5, 1); expect_dec(0, 0, 0, "R7");
    do_start(); send(8'hF6, 1); expect_dec(0, 0, 0, "R4");
    // R7: other first byte forgets the 10-bit write addressing
    do_start(); send(8'hF4, 1); send(8'hC5, 0); expect_dec(1, 1, 1, "R4");
    do_start(); send(8'h74, 1); expect_dec(1, 1, 1, "R2");
    do_start(); send(8'hF5, 1); expect_dec(0, 0, 0, "R7");
    do_stop();
    // R5 disabled
    en10 = 0; do_start(); send(8'hF4, 1); expect_dec(0, 0, 0, "R5");
    en10 = 1;
    // R8 with data enable cleared during 10-bit addressing
    daen = 0; do_start(); send(8'hF4, 1); expect_dec(1, 0, 0, "R8");
    send(8'hC5, 0); expect_dec(1, 1, 1, "R8");
    daen = 1; do_stop();

    // R12 precedence: own7 in prefix form 1111010
    own7 = 7'h7A;
    do_start(); send(8'hF4, 1); expect_dec(1, 0, 0, "R12");
    en10 = 0; do_start(); send(8'hF4, 1); expect_dec(1, 1, 1, "R12");
    do_stop();
    own7 = 7'h00; en10 = 1;
    do_start(); send(8'h00, 1); expect_dec(1, 1, 1, "R12");
    cmp(gen_call, 1'b1, "R12 gc wins");
    gcen = 0; do_start(); send(8'h00, 1); expect_dec(0, 0, 0, "R12");
    do_stop();

    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule